// File: doc/BRIEF.md
# SPI Slave Byte Exchanger

This block is the device side of a four-wire serial peripheral link. It runs on a fast system clock. It brings the external serial clock, the serial data input and the active-low select into that clock domain through two-flop synchronizers, and it finds the serial clock edges there. While selected, it trades one 8-bit word with the bus controller for every eight serial clock cycles. The word it receives shifts into one register while the word it returns shifts out of another.

All four clock polarity/phase modes are supported, and the bit order can be chosen. Each finished word appears on a parallel output together with a strobe that lasts one system cycle, so the strobe can also serve as an interrupt. The word to return is written into a holding register through a load strobe. It is copied into the output shifter when the select falls and again each time a word completes. While the select is high the block ignores the bus, and its serial output enable stays low so that other devices can share the return line.

Top module: `spi_byte_slave`

## Requirements
- R1: While the synchronized select is high, `miso_oe` and `miso_out` are 0, serial clock and data activity is ignored, and `rx_valid` stays 0.
- R2: Within 3 system cycles after `ssn_in` falls, `miso_oe` is 1 and `miso_out` carries the first bit of the holding register. That bit is bit 7 when `cfg_lsb_first`=0 and bit 0 when it is 1. The bit is already present before any serial clock edge.
- R3: Each serial clock cycle receives one bit and sends one bit. After 8 sample edges, `rx_byte` equals the 8 bits taken from `mosi_in`, and the bus controller has read the 8 bits of the transmitted word on `miso_out`.
- R4: With `cfg_lsb_first`=0, words go out MSB first and each received bit enters at bit 0. With `cfg_lsb_first`=1, words go out LSB first and each received bit enters at bit 7.
- R5: The leading edge of the serial clock is rising when `cfg_cpol`=0 and falling when `cfg_cpol`=1. When `cfg_cpha`=0, data is sampled on the leading edge and the next bit is shifted out on the trailing edge. When `cfg_cpha`=1, the leading edge shifts and the trailing edge samples.
- R6: `rx_valid` is high for exactly one system cycle per completed word, together with the new `rx_byte`. `rx_byte` holds its value until the next completed word.
- R7: If the select rises before the 8th sample edge, the partial word is dropped and no `rx_valid` pulse is given. The next selection starts again at bit 0.
- R8: The holding register resets to 0x00 and is written from `tx_byte` when `tx_load` is 1. It is copied into the output shifter when the select falls and after every completed word.
- R9: Several words can follow one another within one selection with no gap. Each word is received and returned as described in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select, 1 sends LSB first |
| sclk_in | input | 1 | Serial clock from the bus controller |
| mosi_in | input | 1 | Serial data from the bus controller |
| ssn_in | input | 1 | Active-low device select |
| tx_byte | input | 8 | Word to return on the next exchange |
| tx_load | input | 1 | Write strobe for the holding register |
| miso_out | output | 1 | Serial data to the bus controller |
| miso_oe | output | 1 | Output enable for `miso_out`, low while deselected |
| rx_byte | output | 8 | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe for a completed word |

## Verification
The properties assume that the configuration inputs change only while the select is high. They also assume that each serial clock level lasts at least two system cycles, so that two completed words can never land on adjacent cycles. The bench keeps every serial clock half period at eight system cycles and changes the mode only between frames. It pulses `tx_load` only at moments when no reload from the holding register can coincide with it. Deliberately ill-formed traffic is limited to clocking while deselected and early deselection, and both of those are legal inputs.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] rx_out;
        logic              rx_vld;
        logic              oe;
    } core_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int unsigned N       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_stb,
    output logic shift_stb
);
    logic prev_d, prev_q;
    logic rise, fall, lead, trail;

    always_comb begin
        prev_d = sclk_s;
        rise   = sclk_s & ~prev_q;
        fall   = ~sclk_s & prev_q;
        lead   = cpol ? fall : rise;
        trail  = cpol ? rise : fall;
        sample_stb = cpha ? trail : lead;
        shift_stb  = cpha ? lead : trail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              ssn_in,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              tx_load,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int unsigned SYNC_N = 3;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [SYNC_N-1:0] bus_s;
    logic ssn_s, sclk_s, mosi_s;
    logic sample_stb, shift_stb;
    logic active, ss_fall;
    logic [WORD_W-1:0] rx_next;
    core_t core_d, core_q;

    // Select idles high so nothing is seen as active out of reset
    spi_slv_sync #(.N(SYNC_N), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ssn_in, sclk_in, mosi_in}),
        .dout (bus_s)
    );
    assign {ssn_s, sclk_s, mosi_s} = bus_s;

    spi_slv_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );

    always_comb begin
        core_d        = core_q;
        core_d.rx_vld = 1'b0;
        active        = ~ssn_s;
        // the registered enable is the select state one cycle ago
        ss_fall       = active & ~core_q.oe;
        core_d.oe     = active;
        rx_next       = cfg_lsb_first ? {mosi_s, core_q.rx_sh[WORD_W-1:1]}
                                      : {core_q.rx_sh[WORD_W-2:0], mosi_s};

        if (tx_load) core_d.hold = tx_byte;

        if (!active) begin
            core_d.cnt   = '0;
            core_d.rx_sh = '0;
        end else if (ss_fall) begin
            core_d.tx_sh = core_q.hold;
            core_d.cnt   = '0;
            core_d.rx_sh = '0;
        end else begin
            if (sample_stb) begin
                if (core_q.cnt == LAST_BIT) begin
                    core_d.cnt    = '0;
                    core_d.rx_sh  = '0;
                    core_d.rx_out = rx_next;
                    core_d.rx_vld = 1'b1;
                    core_d.tx_sh  = core_q.hold;
                end else begin
                    core_d.cnt   = core_q.cnt + 1'b1;
                    core_d.rx_sh = rx_next;
                end
            end
            // first shift edge of a word keeps the preloaded bit
            if (shift_stb && core_q.cnt != '0) begin
                core_d.tx_sh = cfg_lsb_first ? (core_q.tx_sh >> 1)
                                             : (core_q.tx_sh << 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign miso_oe  = core_q.oe;
    assign miso_out = core_q.oe & (cfg_lsb_first ? core_q.tx_sh[0]
                                                 : core_q.tx_sh[WORD_W-1]);
    assign rx_byte  = core_q.rx_out;
    assign rx_valid = core_q.rx_vld;
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_lsb_first,
    input logic          miso_out,
    input logic          miso_oe,
    input logic          rx_valid,
    input logic [W-1:0]  rx_byte,
    input logic [W-1:0]  hold,
    input logic [CW-1:0] bit_cnt
);
    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> (!miso_out && !rx_valid && bit_cnt == '0));

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> (miso_out == (cfg_lsb_first ? $past(hold[0])
                                                        : $past(hold[W-1]))));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(
    .W (spi_slv_pkg::WORD_W),
    .CW(spi_slv_pkg::CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_lsb_first(cfg_lsb_first),
    .miso_out     (miso_out),
    .miso_oe      (miso_oe),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .hold         (core_q.hold),
    .bit_cnt      (core_q.cnt)
);

// File: tb/tb_spi_byte_slave.sv
module tb_spi_byte_slave;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, ssn = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic tx_load = 1'b0;
    logic miso_out, miso_oe, rx_valid;
    logic [7:0] rx_byte;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_n = 0;
    logic [7:0] rx_log [0:255];
    logic prev_vld = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_byte_slave dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_lsb_first(lsb), .sclk_in(sclk), .mosi_in(mosi), .ssn_in(ssn),
        .tx_byte(tx_byte), .tx_load(tx_load), .miso_out(miso_out),
        .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h (mode %0d lsb %0d)",
                     req, act, exp, {cpol, cpha}, lsb);
        end
    endtask

    // R6: log each strobe, flag a strobe longer than one cycle
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_log[rx_n[7:0]] = rx_byte;
            rx_n++;
            if (prev_vld) check(1'b0, "R6 pulse width", 2, 1);
        end
        prev_vld = rx_valid;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] v);
        tx_byte = v; tx_load = 1'b1;
        wait_cyc(1);
        tx_load = 1'b0;
    endtask

    task automatic shift_bits(input logic [7:0] mb, input int nbits,
                              output logic [7:0] got);
        logic rb;
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi = lsb ? mb[i] : mb[7-i];
                wait_cyc(H); rb = miso_out;
                sclk = ~cpol; wait_cyc(H); sclk = cpol;
            end else begin
                sclk = ~cpol; mosi = lsb ? mb[i] : mb[7-i];
                wait_cyc(H); rb = miso_out;
                sclk = cpol; wait_cyc(H);
            end
            got = lsb ? {rb, got[7:1]} : {got[6:0], rb};
        end
    endtask

    task automatic frame(input logic [7:0] m0, input logic [7:0] m1, input int nb,
                         input logic [7:0] t0, input logic [7:0] t1, input bit doload);
        logic [7:0] got, mb, et;
        logic efirst;
        int base;
        sclk = cpol;
        wait_cyc(4);
        if (doload) load(t0);
        wait_cyc(2);
        base = rx_n;
        ssn = 1'b0;
        wait_cyc(4);
        et = doload ? t0 : 8'h00;
        efirst = lsb ? et[0] : et[7];
        check(miso_oe === 1'b1, "R2 oe", miso_oe, 1);
        check(miso_out === efirst, "R2 first bit", miso_out, efirst);
        if (doload && nb > 1) load(t1);
        for (int b = 0; b < nb; b++) begin
            mb = (b == 0) ? m0 : m1;
            shift_bits(mb, 8, got);
            et = !doload ? 8'h00 : ((b == 0) ? t0 : t1);
            // R3 R4 R5 R8 R9: returned word seen by the controller
            check(got === et, "R3/R4/R5/R8/R9 miso word", got, et);
        end
        wait_cyc(H);
        check(rx_n - base == nb, "R6 strobe count", rx_n - base, nb);
        for (int b = 0; b < nb; b++) begin
            et = (b == 0) ? m0 : m1;
            // R3 R4 R5 R9: received word
            check(rx_log[8'(base + b)] === et, "R3/R4/R5/R9 rx word",
                  rx_log[8'(base + b)], et);
        end
        ssn = 1'b1;
        wait_cyc(5);
        check(miso_oe === 1'b0, "R1 oe released", miso_oe, 0);
        check(miso_out === 1'b0, "R1 miso low", miso_out, 0);
    endtask

    function automatic logic [7:0] pat(input int k, input int salt);
        case (k)
            0: pat = 8'h00;
            1: pat = 8'hFF;
            default: pat = 8'((k * 37 + salt * 11 + 1) ^ (k << 4));
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] junk;
        int base;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 R6 R8: reset state
        check(miso_oe === 1'b0, "R1 reset oe", miso_oe, 0);
        check(rx_valid === 1'b0, "R6 reset valid", rx_valid, 0);
        check(rx_byte === 8'h00, "R6 reset rx_byte", rx_byte, 0);

        // R8: default return word without any load
        frame(8'h3C, 8'h00, 1, 8'h00, 8'h00, 1'b0);

        // R1: traffic while deselected is ignored
        base = rx_n;
        for (int i = 0; i < 12; i++) begin
            mosi = i[0]; sclk = ~sclk; wait_cyc(H);
            check(miso_oe === 1'b0 && miso_out === 1'b0, "R1 ignored bus",
                  {miso_oe, miso_out}, 0);
        end
        sclk = cpol;
        check(rx_n == base, "R1 no strobe while deselected", rx_n - base, 0);
        frame(8'h81, 8'h00, 1, 8'h5A, 8'h00, 1'b1);

        // R7: early deselection in every mode
        for (int m = 0; m < 4; m++) begin
            {cpol, cpha} = 2'(m);
            lsb = 1'b0;
            sclk = cpol;
            wait_cyc(4);
            base = rx_n;
            ssn = 1'b0;
            wait_cyc(4);
            shift_bits(8'hA7, 3 + m, junk);
            ssn = 1'b1;
            wait_cyc(H);
            check(rx_n == base, "R7 no strobe on abort", rx_n - base, 0);
            frame(8'hC3, 8'h00, 1, 8'h96, 8'h00, 1'b1);
        end

        // R3 R4 R5 R9: sweep of modes, bit orders and words
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                {cpol, cpha} = 2'(m);
                lsb = o[0];
                for (int k = 0; k < 6; k++) begin
                    frame(pat(k, m * 2 + o), pat(k + 3, m + 7), (k % 2) + 1,
                          pat(k + 1, m + o + 3) ^ 8'hA5, pat(k + 2, o + 5),
                          1'b1);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule